// File: doc/BRIEF.md
# PCI INTx Slot Swizzle Router

This block turns interrupt level changes reported by devices on a PCI bus into sixteen level-sensitive request lines for a legacy interrupt controller. Each report carries the reporting device's devfn byte, the interrupt pin it uses (0 to 3 for A to D) and the new level. A first stage derives a PCI line number from the slot and the pin. Expansion slots rotate the pin by the slot position. A few fixed on-board slots are wired to one line each. Every other slot passes the pin through unchanged.

The block holds one level bit for each of the four PCI lines. A second stage looks each line up in a four-entry, byte-wide steering table written through a simple write port. Each entry names the controller input that its line drives. A controller input is asserted when any line steered to it is high. An entry of 16 or more detaches its line from every output.

The outputs are a combinational function of the stored levels and the table. A level report or a table write therefore shows on the outputs right after the clock edge that captures it. Controller prioritisation and acknowledge handling belong elsewhere.

Top module: `intx_router`

## Requirements
- R1: After reset every output is low and all four table entries hold 0x80 (disabled), so a raised PCI line drives no output until its entry is written.
- R2: The slot is devfn bits 7:3. For slots 18 to 21 the PCI line is ((slot - 18) + pin) mod 4, where pin 0..3 stands for INTA..INTD.
- R3: A device in a slot that is neither an expansion slot (18 to 21) nor an on-board slot keeps its pin number as its PCI line.
- R4: By default the on-board slots 10, 11 and 12 drive PCI lines 3, 0 and 1, whatever their pin.
- R5: Each PCI line keeps the level of the most recent report that mapped to it. A later report from any device on that line overwrites the earlier one.
- R6: A cycle with the table write enable high stores the data byte into the entry selected by the 2-bit index. The new steering applies to the outputs from the next clock edge.
- R7: Output k is the OR of the levels of all PCI lines whose table entry equals k.
- R8: A table entry of 16 or greater makes its PCI line drive no output.
- R9: Rewriting an entry while its line is high releases the old output and asserts the new one after the same clock edge, unless another line still holds the old output.
- R10: A level report presented in a cycle is visible on the outputs immediately after the clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | A device reports an interrupt level this cycle |
| evt_devfn | input | 8 | Device and function number of the reporting device |
| evt_pin | input | 2 | Interrupt pin of the device, 0..3 for INTA..INTD |
| evt_level | input | 1 | New level of that pin |
| tbl_we | input | 1 | Write one steering table entry |
| tbl_idx | input | 2 | PCI line whose entry is written |
| tbl_data | input | 8 | Controller input number; 16 or more disables the line |
| irq_out | output | 16 | Level-sensitive controller request lines |

## Verification
The bench targets the edges of the expansion slot window: slots 17 and 22 must pass the pin through, and a design that compared the window bounds wrongly would rotate them. It exercises the wrap of the rotation at slot 21 with high pins, where a missing modulo would select a nonexistent line. It also covers shared controller inputs, where a design that computed only the last written line would drop a request still held by another line. Finally it checks retargeting and disabling an entry while the line is high, where a design that updated only the new output would leave a stale request asserted, and the case where two devices share one line and the later report clears it.

// File: rtl/intx_pkg.sv
package intx_pkg;

  typedef logic [4:0] slot_t;

  // Rotate a device pin by its offset inside the expansion slot window.
  function automatic logic [1:0] rotate_pin(input slot_t slot, input slot_t base,
                                            input logic [1:0] pin);
    slot_t off;
    off = slot - base;
    return off[1:0] + pin;
  endfunction

  // True when the slot lies in [base, base+count).
  function automatic logic in_window(input slot_t slot, input slot_t base,
                                     input slot_t count);
    return (slot >= base) && (slot < base + count);
  endfunction

endpackage

// File: rtl/intx_swizzle.sv
module intx_swizzle
  import intx_pkg::*;
#(
  parameter int N_LINES   = 4,
  parameter int SLOT_BASE = 18,
  parameter int ONB_SLOT0 = 10,
  parameter int ONB_LINE0 = 3,
  parameter int ONB_SLOT1 = 11,
  parameter int ONB_LINE1 = 0,
  parameter int ONB_SLOT2 = 12,
  parameter int ONB_LINE2 = 1,
  localparam int LINE_W   = $clog2(N_LINES)
) (
  input  logic [7:0]        devfn,
  input  logic [1:0]        pin,
  output logic [LINE_W-1:0] line
);

  slot_t slot;
  assign slot = devfn[7:3];

  always_comb begin
    if (in_window(slot, slot_t'(SLOT_BASE), slot_t'(N_LINES)))
      line = LINE_W'(rotate_pin(slot, slot_t'(SLOT_BASE), pin));
    else if (slot == slot_t'(ONB_SLOT0))
      line = LINE_W'(ONB_LINE0);
    else if (slot == slot_t'(ONB_SLOT1))
      line = LINE_W'(ONB_LINE1);
    else if (slot == slot_t'(ONB_SLOT2))
      line = LINE_W'(ONB_LINE2);
    else
      line = LINE_W'(pin);
  end

endmodule

// File: rtl/intx_level_store.sv
module intx_level_store #(
  parameter int N_LINES = 4,
  localparam int LINE_W = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd,
  input  logic [LINE_W-1:0]  upd_line,
  input  logic               upd_level,
  output logic [N_LINES-1:0] level_q
);

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (!rst_n)
        level_q[i] <= 1'b0;
      else if (upd && (upd_line == LINE_W'(i)))
        level_q[i] <= upd_level;
    end
  end

endmodule

// File: rtl/intx_route_table.sv
module intx_route_table #(
  parameter int N_LINES         = 4,
  parameter int ENTRY_W         = 8,
  parameter logic [7:0] TBL_RST = 8'h80,
  localparam int LINE_W         = $clog2(N_LINES)
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [LINE_W-1:0]               idx,
  input  logic [ENTRY_W-1:0]              data,
  output logic [N_LINES-1:0][ENTRY_W-1:0] tbl_q
);

  for (genvar i = 0; i < N_LINES; i++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n)
        tbl_q[i] <= ENTRY_W'(TBL_RST);
      else if (we && (idx == LINE_W'(i)))
        tbl_q[i] <= data;
    end
  end

endmodule

// File: rtl/intx_or_matrix.sv
module intx_or_matrix #(
  parameter int N_LINES = 4,
  parameter int N_OUT   = 16,
  parameter int ENTRY_W = 8
) (
  input  logic [N_LINES-1:0]              level_q,
  input  logic [N_LINES-1:0][ENTRY_W-1:0] tbl_q,
  output logic [N_OUT-1:0]                irq
);

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    logic [N_LINES-1:0] hit;
    for (genvar i = 0; i < N_LINES; i++) begin : g_src
      assign hit[i] = level_q[i] && (tbl_q[i] == ENTRY_W'(k));
    end
    assign irq[k] = |hit;
  end

endmodule

// File: rtl/intx_router.sv
module intx_router #(
  parameter int N_LINES         = 4,
  parameter int N_OUT           = 16,
  parameter int ENTRY_W         = 8,
  parameter int SLOT_BASE       = 18,
  parameter int ONB_SLOT0       = 10,
  parameter int ONB_LINE0       = 3,
  parameter int ONB_SLOT1       = 11,
  parameter int ONB_LINE1       = 0,
  parameter int ONB_SLOT2       = 12,
  parameter int ONB_LINE2       = 1,
  parameter logic [7:0] TBL_RST = 8'h80
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [7:0]       evt_devfn,
  input  logic [1:0]       evt_pin,
  input  logic             evt_level,
  input  logic             tbl_we,
  input  logic [1:0]       tbl_idx,
  input  logic [7:0]       tbl_data,
  output logic [N_OUT-1:0] irq_out
);

  localparam int LINE_W = $clog2(N_LINES);

  logic [LINE_W-1:0]               line_sel;
  logic [N_LINES-1:0]              level_q;
  logic [N_LINES-1:0][ENTRY_W-1:0] tbl_q;

  intx_swizzle #(
    .N_LINES(N_LINES), .SLOT_BASE(SLOT_BASE),
    .ONB_SLOT0(ONB_SLOT0), .ONB_LINE0(ONB_LINE0),
    .ONB_SLOT1(ONB_SLOT1), .ONB_LINE1(ONB_LINE1),
    .ONB_SLOT2(ONB_SLOT2), .ONB_LINE2(ONB_LINE2)
  ) u_swz (
    .devfn(evt_devfn), .pin(evt_pin), .line(line_sel)
  );

  intx_level_store #(.N_LINES(N_LINES)) u_lvl (
    .clk(clk), .rst_n(rst_n), .upd(evt_valid), .upd_line(line_sel),
    .upd_level(evt_level), .level_q(level_q)
  );

  intx_route_table #(.N_LINES(N_LINES), .ENTRY_W(ENTRY_W), .TBL_RST(TBL_RST)) u_tbl (
    .clk(clk), .rst_n(rst_n), .we(tbl_we), .idx(LINE_W'(tbl_idx)),
    .data(ENTRY_W'(tbl_data)), .tbl_q(tbl_q)
  );

  intx_or_matrix #(.N_LINES(N_LINES), .N_OUT(N_OUT), .ENTRY_W(ENTRY_W)) u_or (
    .level_q(level_q), .tbl_q(tbl_q), .irq(irq_out)
  );

endmodule

// File: rtl/intx_router_chk.sv
module intx_router_chk #(
  parameter int N_LINES   = 4,
  parameter int N_OUT     = 16,
  parameter int ENTRY_W   = 8,
  parameter int SLOT_BASE = 18,
  parameter int ONB_SLOT0 = 10,
  parameter int ONB_LINE0 = 3,
  localparam int LINE_W   = $clog2(N_LINES)
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            evt_valid,
  input logic [7:0]                      evt_devfn,
  input logic [1:0]                      evt_pin,
  input logic                            evt_level,
  input logic                            tbl_we,
  input logic [1:0]                      tbl_idx,
  input logic [7:0]                      tbl_data,
  input logic [N_OUT-1:0]                irq_out,
  input logic [LINE_W-1:0]               line_sel,
  input logic [N_LINES-1:0]              level_q,
  input logic [N_LINES-1:0][ENTRY_W-1:0] tbl_q
);

  logic all_off;
  always_comb begin
    all_off = 1'b1;
    for (int i = 0; i < N_LINES; i++)
      if (tbl_q[i] < ENTRY_W'(N_OUT)) all_off = 1'b0;
  end

  assert_base_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_devfn[7:3] == 5'(SLOT_BASE)) |-> (line_sel == LINE_W'(evt_pin)));

  assert_slot_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_devfn[7:3] == 5'd0) |-> (line_sel == LINE_W'(evt_pin)));

  assert_onboard_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && evt_devfn[7:3] == 5'(ONB_SLOT0)) |-> (line_sel == LINE_W'(ONB_LINE0)));

  assert_level_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_valid |=> (level_q[$past(line_sel)] == $past(evt_level)));

  assert_table_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_we |=> (tbl_q[$past(tbl_idx)] == ENTRY_W'($past(tbl_data))));

  assert_fanout_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(irq_out) <= $countones(level_q));

  assert_all_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
    all_off |-> (irq_out == '0));

endmodule

bind intx_router intx_router_chk #(
  .N_LINES(N_LINES), .N_OUT(N_OUT), .ENTRY_W(ENTRY_W), .SLOT_BASE(SLOT_BASE),
  .ONB_SLOT0(ONB_SLOT0), .ONB_LINE0(ONB_LINE0)
) u_chk (
  .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_devfn(evt_devfn),
  .evt_pin(evt_pin), .evt_level(evt_level), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
  .tbl_data(tbl_data), .irq_out(irq_out), .line_sel(line_sel),
  .level_q(level_q), .tbl_q(tbl_q)
);

// File: tb/intx_router_tb.sv
`timescale 1ns/1ps
module intx_router_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        evt_valid, evt_level, tbl_we;
  logic [7:0]  evt_devfn, tbl_data;
  logic [1:0]  evt_pin, tbl_idx;
  logic [15:0] irq_out;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  string cur_req = "R1";

  int ref_lvl[4];
  int ref_tbl[4];

  always #2.5 clk = ~clk;

  intx_router u_dut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_devfn(evt_devfn),
    .evt_pin(evt_pin), .evt_level(evt_level), .tbl_we(tbl_we),
    .tbl_idx(tbl_idx), .tbl_data(tbl_data), .irq_out(irq_out)
  );

  function automatic int ref_line(int devfn, int pin);
    int s = devfn / 8;
    if (s >= 18 && s <= 21) return (s - 18 + pin) % 4;
    case (s)
      10: return 3;
      11: return 0;
      12: return 1;
      default: return pin;
    endcase
  endfunction

  function automatic logic [15:0] ref_out();
    logic [15:0] o = '0;
    foreach (ref_lvl[i])
      if (ref_lvl[i] != 0 && ref_tbl[i] < 16) o[ref_tbl[i]] = 1'b1;
    return o;
  endfunction

  // One clock: model follows the inputs captured at the edge, compare after.
  task automatic cyc();
    @(posedge clk);
    if (!rst_n) begin
      foreach (ref_lvl[i]) begin ref_lvl[i] = 0; ref_tbl[i] = 8'h80; end
    end else begin
      if (evt_valid) ref_lvl[ref_line(evt_devfn, evt_pin)] = evt_level;
      if (tbl_we) ref_tbl[tbl_idx] = tbl_data;
    end
    @(negedge clk);
    total++;
    if (irq_out !== ref_out()) begin
      bad++;
      $display("FAIL %s irq_out=%h expected=%h", cur_req, irq_out, ref_out());
    end
  endtask

  task automatic ev(int slot, int fn, int pin, int lvl);
    evt_valid = 1'b1; evt_devfn = 8'(slot * 8 + fn); evt_pin = 2'(pin);
    evt_level = 1'(lvl);
    cyc();
    evt_valid = 1'b0;
    cyc();
  endtask

  task automatic wr(int idx, int val);
    tbl_we = 1'b1; tbl_idx = 2'(idx); tbl_data = 8'(val);
    cyc();
    tbl_we = 1'b0;
    cyc();
  endtask

  initial begin
    rst_n = 1'b0; evt_valid = 0; evt_level = 0; tbl_we = 0;
    evt_devfn = 0; evt_pin = 0; tbl_idx = 0; tbl_data = 0;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();
    // R1: raised line with the reset table drives nothing
    cur_req = "R1"; ev(18, 0, 0, 1); ev(20, 0, 1, 1);
    // R6: program the table
    cur_req = "R6"; wr(0, 3); wr(1, 5); wr(2, 7); wr(3, 9);
    ev(0, 0, 0, 0); ev(0, 0, 3, 0);
    // R2: expansion slot rotation including wrap at slot 21
    cur_req = "R2";
    for (int s = 18; s <= 21; s++)
      for (int p = 0; p < 4; p++) begin ev(s, p % 8, p, 1); ev(s, 0, p, 0); end
    ev(21, 0, 3, 1); ev(21, 0, 3, 0);
    // R3: slots outside every window, including window neighbours
    cur_req = "R3";
    ev(17, 0, 1, 1); ev(22, 0, 2, 1); ev(0, 5, 3, 1); ev(31, 7, 0, 1);
    ev(17, 0, 1, 0); ev(22, 0, 2, 0); ev(0, 5, 3, 0); ev(31, 7, 0, 0);
    // R4: on-board slots
    cur_req = "R4";
    ev(10, 0, 0, 1); ev(11, 0, 2, 1); ev(12, 0, 3, 1);
    ev(10, 0, 1, 0); ev(11, 0, 0, 0); ev(12, 0, 2, 0);
    // R5: two devices share line 1; the later report wins
    cur_req = "R5";
    ev(18, 0, 1, 1); ev(19, 0, 0, 0); ev(19, 0, 0, 1); ev(18, 0, 1, 0);
    // R7: lines 1 and 2 share output 3 with line 0
    cur_req = "R7";
    wr(1, 3); wr(2, 3);
    ev(18, 0, 1, 1); ev(18, 0, 2, 1); ev(18, 0, 1, 0); ev(18, 0, 2, 0);
    // R9: retarget a high line, with and without a co-owner of the old output
    cur_req = "R9";
    ev(18, 0, 1, 1); wr(1, 4); ev(18, 0, 2, 1); wr(2, 4); wr(2, 15);
    // R8: disabling values
    cur_req = "R8";
    wr(1, 16); wr(2, 8'hFF); wr(2, 0); wr(2, 17);
    // R10: random mix checked every clock
    cur_req = "R10";
    for (int n = 0; n < 3000; n++) begin
      evt_valid = 1'($urandom_range(0, 1));
      evt_devfn = 8'($urandom_range(0, 255));
      evt_pin   = 2'($urandom_range(0, 3));
      evt_level = 1'($urandom_range(0, 1));
      tbl_we    = ($urandom_range(0, 7) == 0);
      tbl_idx   = 2'($urandom_range(0, 3));
      tbl_data  = ($urandom_range(0, 5) == 0) ? 8'($urandom_range(16, 255))
                                              : 8'($urandom_range(0, 15));
      cyc();
    end
    evt_valid = 0; tbl_we = 0;
    cyc();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog %s irq_out=%h expected=finish", cur_req, irq_out);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule